// File: doc/BRIEF.md
# Daisy-Chain Interrupt Unit with Vector Modify

This block raises a single interrupt request on behalf of a transfer engine. It reacts to three event pulses: a ready rising edge, a search match and end of block. A control byte enables each cause separately, and a global enable gate sits on top of that. Priority among several interrupting units is resolved by a daisy chain. Each unit passes an enable input on to an enable output, and it breaks the chain while it has a request pending or is being serviced. During acknowledge the unit supplies an 8-bit vector. A control bit can make the unit rewrite two bits of that vector with a code for the cause.

The unit is a three-state machine:
- `ST_IDLE` means no request is held.
- `ST_PEND` means a request has been latched and waits for acknowledge.
- `ST_SERV` means the request has been acknowledged and the handler is running.

Its transitions are:
- *accept* (`ST_IDLE` to `ST_PEND`): the global enable is set and at least one enabled event pulses.
- *acknowledge* (`ST_PEND` to `ST_SERV`): the acknowledge strobe arrives while the chain input is high.
- *return* (`ST_SERV` to `ST_IDLE`): the return-from-interrupt strobe arrives.

In every other case the state holds. All inputs are sampled on the rising clock edge. The outputs are combinational functions of the registered state and the present inputs.

Top module: `irq_chain_unit`

## Requirements
- R1: After reset the unit is in `ST_IDLE`, the global enable is clear, the latched cause is 0, `int_req` is 0 and `ieo` equals `iei`.
- R2: `cmd_int_on` sets the global enable and `cmd_int_off` clears it, from the next edge on. When both arrive in the same cycle, the enable ends up clear. While the enable is clear, no event is accepted.
- R3: Each cause is enabled by its own bit of `irq_ctrl`: bit 0 for match, bit 1 for end of block and bit 6 for ready. An event whose bit is 0 causes no request.
- R4: The cause codes are ready = 0, match = 1 and end of block = 2. When several enabled events arrive in the same accepting cycle, the latched cause is the bitwise OR of their codes.
- R5: When `irq_ctrl` bit 5 is 1, `vec_out` equals `(vec_base & 8'hF9) | (cause << 1)`. When the bit is 0, `vec_out` equals `vec_base`.
- R6: A request is accepted only in `ST_IDLE`. Events that arrive in `ST_PEND` or `ST_SERV` are ignored, and the latched cause does not change.
- R7: `int_req` is 1 exactly when `iei` is 1 and the unit is in `ST_PEND`.
- R8: An acknowledge moves `ST_PEND` to `ST_SERV` only when `iei` is 1. In any other state, or with `iei` low, an acknowledge has no effect.
- R9: `reti_seen` returns `ST_SERV` to `ST_IDLE`. `reti_fwd` copies `reti_seen` whenever the unit is not in `ST_SERV`, and is 0 while the unit is in `ST_SERV`.
- R10: `ieo` is 1 exactly when `iei` is 1 and the unit is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_int_on | input | 1 | One-cycle command to set the global interrupt enable |
| cmd_int_off | input | 1 | One-cycle command to clear the global interrupt enable |
| ev_ready | input | 1 | Ready rising-edge event pulse |
| ev_match | input | 1 | Search match event pulse |
| ev_eob | input | 1 | End-of-block event pulse |
| irq_ctrl | input | 8 | Per-cause enables and vector-modify select |
| vec_base | input | 8 | Base interrupt vector |
| iei | input | 1 | Daisy-chain enable in (high = no higher unit active) |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| reti_seen | input | 1 | Return-from-interrupt strobe |
| int_req | output | 1 | Interrupt request |
| ieo | output | 1 | Daisy-chain enable out |
| vec_out | output | 8 | Vector returned on acknowledge |
| reti_fwd | output | 1 | Return-from-interrupt passed down the chain |

## Verification
The assertions assume that every strobe and event is a single-cycle level sampled at the rising edge. They also assume that `irq_ctrl` and `vec_base` are stable during the cycle in which they are sampled. Nothing is assumed about the order of strobes: the properties must hold even when an acknowledge or a return arrives in the wrong state. The stimulus therefore changes every input only at the falling edge. A pseudo-random phase freely combines commands, events, acknowledges and returns, including ones that are out of order.

// File: rtl/icu_pkg.sv
package icu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_SERV = 2'd2
    } icu_state_t;

    localparam int NUM_CAUSE = 3;
    localparam int CAUSE_W   = 2;

    // cause identifiers double as cause codes
    localparam int ID_READY = 0;
    localparam int ID_MATCH = 1;
    localparam int ID_EOB   = 2;

    // control byte bit positions
    localparam int EN_BIT_MATCH   = 0;
    localparam int EN_BIT_EOB     = 1;
    localparam int STATUS_VEC_BIT = 5;
    localparam int EN_BIT_READY   = 6;

    // lowest vector bit overwritten by the cause code
    localparam int VEC_CAUSE_LSB = 1;

    function automatic int en_bit(input int id);
        case (id)
            ID_READY: return EN_BIT_READY;
            ID_MATCH: return EN_BIT_MATCH;
            default:  return EN_BIT_EOB;
        endcase
    endfunction

endpackage

// File: rtl/icu_gate_en.sv
module icu_gate_en (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_on,
    input  logic cmd_off,
    output logic en_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (cmd_off) begin
            en_q <= 1'b0;
        end else if (cmd_on) begin
            en_q <= 1'b1;
        end
    end

    assert_off_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> !en_q);

    assert_on_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_on && !cmd_off) |=> en_q);

endmodule

// File: rtl/icu_cause_enc.sv
module icu_cause_enc
    import icu_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic [NUM_CAUSE-1:0] ev,
    input  logic [CTRL_W-1:0]    ctrl,
    output logic                 hit,
    output logic [CAUSE_W-1:0]   code
);

    logic [NUM_CAUSE-1:0] masked;

    generate
        for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_mask
            localparam int BIT_SEL = en_bit(g);
            assign masked[g] = ev[g] & ctrl[BIT_SEL];
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_CAUSE; i++) begin
            if (masked[i]) begin
                code = code | CAUSE_W'(i);
            end
        end
    end

    assign hit = |masked;

endmodule

// File: rtl/icu_vec_fmt.sv
module icu_vec_fmt
    import icu_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic               modify,
    input  logic [VEC_W-1:0]   base,
    input  logic [CAUSE_W-1:0] cause,
    output logic [VEC_W-1:0]   vec
);

    localparam logic [VEC_W-1:0] FIELD_MASK =
        VEC_W'(((1 << CAUSE_W) - 1) << VEC_CAUSE_LSB);

    logic [VEC_W-1:0] shifted;

    assign shifted = VEC_W'(cause) << VEC_CAUSE_LSB;

    always_comb begin
        if (modify) begin
            vec = (base & ~FIELD_MASK) | shifted;
        end else begin
            vec = base;
        end
    end

endmodule

// File: rtl/irq_chain_unit.sv
module irq_chain_unit
    import icu_pkg::*;
#(
    parameter int CTRL_W = 8,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_int_on,
    input  logic              cmd_int_off,
    input  logic              ev_ready,
    input  logic              ev_match,
    input  logic              ev_eob,
    input  logic [CTRL_W-1:0] irq_ctrl,
    input  logic [VEC_W-1:0]  vec_base,
    input  logic              iei,
    input  logic              int_ack,
    input  logic              reti_seen,
    output logic              int_req,
    output logic              ieo,
    output logic [VEC_W-1:0]  vec_out,
    output logic              reti_fwd
);

    icu_state_t           st_q;
    icu_state_t           st_d;
    logic                 en_q;
    logic                 hit;
    logic [CAUSE_W-1:0]   code;
    logic [CAUSE_W-1:0]   cause_q;
    logic [NUM_CAUSE-1:0] ev_vec;
    logic                 accept;

    assign ev_vec[ID_READY] = ev_ready;
    assign ev_vec[ID_MATCH] = ev_match;
    assign ev_vec[ID_EOB]   = ev_eob;

    icu_gate_en u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_on  (cmd_int_on),
        .cmd_off (cmd_int_off),
        .en_q    (en_q)
    );

    icu_cause_enc #(.CTRL_W(CTRL_W)) u_enc (
        .ev   (ev_vec),
        .ctrl (irq_ctrl),
        .hit  (hit),
        .code (code)
    );

    icu_vec_fmt #(.VEC_W(VEC_W)) u_vec (
        .modify (irq_ctrl[STATUS_VEC_BIT]),
        .base   (vec_base),
        .cause  (cause_q),
        .vec    (vec_out)
    );

    assign accept = (st_q == ST_IDLE) && en_q && hit;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (en_q && hit)      st_d = ST_PEND;
            ST_PEND: if (int_ack && iei)   st_d = ST_SERV;
            ST_SERV: if (reti_seen)        st_d = ST_IDLE;
            default:                       st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cause_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                cause_q <= code;
            end
        end
    end

    // outputs
    always_comb begin
        int_req  = 1'b0;
        ieo      = 1'b0;
        reti_fwd = reti_seen;
        unique case (st_q)
            ST_IDLE: ieo      = iei;
            ST_PEND: int_req  = iei;
            ST_SERV: reti_fwd = 1'b0;
            default: ieo      = iei;
        endcase
    end

    assert_no_accept_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !en_q) |=> (st_q == ST_IDLE));

    assert_cause_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(cause_q));

    assert_ack_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PEND && int_ack && iei) |=> (st_q == ST_SERV));

    assert_ack_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PEND && !iei) |=> (st_q == ST_PEND));

    assert_reti_leave_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SERV && reti_seen) |=> (st_q == ST_IDLE));

    assert_chain_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ieo && int_req));

    assert_req_needs_iei_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> iei);

endmodule

// File: tb/irq_chain_unit_tb_top.sv
module irq_chain_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_int_on = 1'b0, cmd_int_off = 1'b0;
    logic       ev_ready = 1'b0, ev_match = 1'b0, ev_eob = 1'b0;
    logic [7:0] irq_ctrl = 8'h00, vec_base = 8'h00;
    logic       iei = 1'b1, int_ack = 1'b0, reti_seen = 1'b0;
    logic       int_req, ieo, reti_fwd;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model: 0 idle, 1 pending, 2 in service
    int m_st = 0;
    int m_en = 0;
    int m_cause = 0;

    always #5 clk = ~clk;

    irq_chain_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_int_on(cmd_int_on), .cmd_int_off(cmd_int_off),
        .ev_ready(ev_ready), .ev_match(ev_match), .ev_eob(ev_eob),
        .irq_ctrl(irq_ctrl), .vec_base(vec_base),
        .iei(iei), .int_ack(int_ack), .reti_seen(reti_seen),
        .int_req(int_req), .ieo(ieo), .vec_out(vec_out), .reti_fwd(reti_fwd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_vec();
        if (irq_ctrl[5]) return (vec_base & 8'hF9) | 8'(m_cause << 1);
        return vec_base;
    endfunction

    task automatic model_step();
        int hitv, codev;
        if (!rst_n) begin
            m_st = 0; m_en = 0; m_cause = 0;
            return;
        end
        hitv  = (ev_ready & irq_ctrl[6]) | (ev_match & irq_ctrl[0]) | (ev_eob & irq_ctrl[1]);
        codev = ((ev_match & irq_ctrl[0]) ? 1 : 0) | ((ev_eob & irq_ctrl[1]) ? 2 : 0);
        case (m_st)
            0: if (m_en != 0 && hitv != 0) begin m_st = 1; m_cause = codev; end
            1: if (int_ack && iei) m_st = 2;
            default: if (reti_seen) m_st = 0;
        endcase
        if (cmd_int_off) m_en = 0;
        else if (cmd_int_on) m_en = 1;
    endtask

    // compare just before the rising edge, then advance the model
    task automatic cyc();
        #2;
        chk("R7 int_req", {7'd0, int_req}, {7'd0, (iei && m_st == 1)});
        chk("R10 ieo", {7'd0, ieo}, {7'd0, (iei && m_st == 0)});
        chk("R5 vec_out", vec_out, exp_vec());
        chk("R9 reti_fwd", {7'd0, reti_fwd}, {7'd0, (reti_seen && m_st != 2)});
        model_step();
        @(negedge clk);
    endtask

    task automatic clr();
        cmd_int_on = 0; cmd_int_off = 0;
        ev_ready = 0; ev_match = 0; ev_eob = 0;
        int_ack = 0; reti_seen = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        @(negedge clk);
        cyc(); cyc();
        // R1 reset state
        #1; chk("R1 int_req after reset", {7'd0, int_req}, 8'd0);
        chk("R1 ieo after reset", {7'd0, ieo}, 8'd1);
        rst_n = 1;
        irq_ctrl = 8'h43; vec_base = 8'hFF;
        cyc();
        // R2: events with global enable clear are ignored
        ev_eob = 1; cyc(); clr();
        #1; chk("R2 no request while disabled", {7'd0, int_req}, 8'd0);
        cmd_int_on = 1; cyc(); clr();
        ev_eob = 1; cyc(); clr();
        #1; chk("R2 request after enable", {7'd0, int_req}, 8'd1);
        chk("R5 unmodified vector", vec_out, 8'hFF);
        irq_ctrl = 8'h63;
        #1; chk("R4 eob code in vector", vec_out, 8'hFD);
        // R6 match while pending ignored
        ev_match = 1; cyc(); clr();
        #1; chk("R6 cause held while pending", vec_out, 8'hFD);
        // R7/R8: iei low masks request and acknowledge
        iei = 0; int_ack = 1;
        #1; chk("R7 masked by iei", {7'd0, int_req}, 8'd0);
        cyc(); clr(); iei = 1;
        #1; chk("R8 ack ignored with iei low", {7'd0, int_req}, 8'd1);
        int_ack = 1; cyc(); clr();
        #1; chk("R8 in service after ack", {7'd0, int_req | ieo}, 8'd0);
        ev_ready = 1; ev_match = 1; cyc(); clr();
        reti_seen = 1;
        #1; chk("R9 reti not forwarded in service", {7'd0, reti_fwd}, 8'd0);
        cyc(); clr();
        #1; chk("R9 idle after return", {7'd0, ieo}, 8'd1);
        chk("R6 cause kept in service", vec_out, 8'hFD);
        reti_seen = 1;
        #1; chk("R9 reti forwarded when idle", {7'd0, reti_fwd}, 8'd1);
        cyc(); clr();
        // R3 disabled cause
        irq_ctrl = 8'h62; ev_match = 1; cyc(); clr();
        #1; chk("R3 disabled match ignored", {7'd0, int_req}, 8'd0);
        ev_ready = 1; cyc(); clr();
        #1; chk("R4 ready code 0", vec_out, 8'hF9);
        int_ack = 1; cyc(); clr(); reti_seen = 1; cyc(); clr();
        // R4 simultaneous causes OR together
        irq_ctrl = 8'h23; vec_base = 8'h00;
        ev_match = 1; ev_eob = 1; cyc(); clr();
        #1; chk("R4 match+eob code 3", vec_out, 8'h06);
        int_ack = 1; cyc(); clr(); reti_seen = 1; cyc(); clr();
        // R2 off wins over on
        cmd_int_on = 1; cmd_int_off = 1; cyc(); clr();
        ev_eob = 1; cyc(); clr();
        #1; chk("R2 off wins", {7'd0, int_req}, 8'd0);
        // random phase
        lf = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cmd_int_on  = lf[0] & lf[1];
            cmd_int_off = lf[2] & lf[3] & lf[4];
            ev_ready = lf[5] & lf[6];
            ev_match = lf[7] & lf[8];
            ev_eob   = lf[9] & lf[10];
            int_ack  = lf[11];
            reti_seen = lf[12] & lf[13];
            iei = lf[14] | lf[15];
            if (lf[16] & lf[17] & lf[18]) irq_ctrl = lf[26:19];
            if (lf[27] & lf[28]) vec_base = lf[31:24];
            cyc();
        end
        clr();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule